// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block merges up to four layer pixels into one RGB output pixel per transaction. Each layer supplies an enable bit, a coverage flag for the current pixel, an ARGB8888 pixel, a pipe select, a priority and an optional global alpha. Composition happens in two stages. First, each of the two pipes keeps the single covering layer with the highest priority. No mixing happens inside a pipe. Second, pipe 0 is blended over the background colour, and pipe 1 is then blended over that result.

A build parameter models a known hardware defect. When it is set and the winner of pipe 0 has priority 0 and a non-opaque effective alpha, that pipe shows the background colour instead of its pixel.

Pixels enter and leave on a valid/ready stream with one register stage. `in_ready` is high whenever the output stage is empty or being drained (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output pixel is held unchanged. The background colour is a plain register, written with `bg_wr`/`bg_data`.

Top module: `layer_compositor`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the background colour is black (0x000000), so a pixel with no contributing layer comes out as 0x000000.
- R2: A layer whose enable bit is 0, or whose coverage flag is 0, never contributes to the output pixel.
- R3: Within one pipe, the covering enabled layer with the numerically largest priority supplies that pipe's pixel unblended. On equal priorities, the lower layer index wins.
- R4: Pixels are ARGB8888 (alpha bits 31:24, red 23:16, green 15:8, blue 7:0) and `out_pixel` is RGB (red 23:16, green 15:8, blue 7:0). Each blend computes (A*fg + (255-A)*bg + 127)/255 per channel. Pipe 0 is blended over the background, then pipe 1 is blended over that result. A `lay_pipe` bit of 1 selects pipe 1.
- R5: With the global-alpha enable set, a layer's effective alpha is (pixel_alpha*global_alpha + 127)/255.
- R6: With the global-alpha enable clear, the global alpha value has no effect and the pixel alpha is used alone.
- R7: A pipe with no contributing layer passes the background colour through. A `bg_wr` pulse loads `bg_data` into the background register on that clock edge.
- R8: With LOWEST_ALPHA_DEFECT=1, a pipe-0 winner with priority 0 and effective alpha below 255 is replaced by the background colour. Winners with priority above 0, or that are opaque, are unaffected. With the parameter at 0, no replacement happens.
- R9: An accepted input (`in_valid && in_ready`) appears on `out_pixel` with `out_valid` one cycle later. A stalled output holds its value, and `in_ready` is low while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bg_wr | input | 1 | Load strobe for the background colour |
| bg_data | input | 24 | Background colour to load (RGB) |
| in_valid | input | 1 | Layer inputs hold a pixel |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| lay_en | input | NUM_LAYERS | Per-layer enable |
| lay_cov | input | NUM_LAYERS | Per-layer coverage of this pixel |
| lay_pipe | input | NUM_LAYERS | Per-layer pipe select (0 or 1) |
| lay_prio | input | NUM_LAYERS*PRIO_W | Per-layer priority, layer i at [i*PRIO_W +: PRIO_W] |
| lay_ga_en | input | NUM_LAYERS | Per-layer global-alpha enable |
| lay_ga | input | NUM_LAYERS*8 | Per-layer global alpha, layer i at [i*8 +: 8] |
| lay_pix | input | NUM_LAYERS*32 | Per-layer ARGB8888 pixel, layer i at [i*32 +: 32] |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | 24 | Composited RGB pixel |

## Verification
Two functions can meet in the same cycle: a stall on the output stream and a new pixel arriving at the input. The bench holds `out_ready` low while a first pixel sits in the output register and presents a different pixel at the input. It then checks three things: the output keeps the first pixel, `in_ready` stays low, and the second pixel appears only on the cycle after `out_ready` returns. Two instances run side by side, one with the defect model enabled and one with it disabled, so that the priority-0 replacement can be compared against the normal blend for identical inputs. The bench also checks a priority-0 alpha layer over a non-black background after a `bg_wr` load.

// File: rtl/comp_pkg.sv
package comp_pkg;

  localparam int unsigned PIX_W = 32;
  localparam int unsigned RGB_W = 24;
  localparam int unsigned CH_W  = 8;

  typedef struct packed {
    logic             hit;
    logic             lowest;
    logic [CH_W-1:0]  alpha;
    logic [RGB_W-1:0] rgb;
  } pipe_res_t;

  function automatic logic [CH_W-1:0] div255_round(input logic [15:0] prod);
    logic [16:0] t;
    t = {1'b0, prod} + 17'd127;
    return CH_W'(t / 17'd255);
  endfunction

endpackage

// File: rtl/comp_pipe_arbiter.sv
module comp_pipe_arbiter
  import comp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int PRIO_W     = 2,
  parameter int PIPE_ID    = 0
) (
  input  logic [NUM_LAYERS-1:0]        en,
  input  logic [NUM_LAYERS-1:0]        cov,
  input  logic [NUM_LAYERS-1:0]        pipe_sel,
  input  logic [NUM_LAYERS*PRIO_W-1:0] prio,
  input  logic [NUM_LAYERS-1:0]        ga_en,
  input  logic [NUM_LAYERS*CH_W-1:0]   ga,
  input  logic [NUM_LAYERS*PIX_W-1:0]  pix,
  output pipe_res_t                    res
);

  localparam int IDX_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;

  logic              found;
  logic [IDX_W-1:0]  best_i;
  logic [PRIO_W-1:0] best_p;
  logic [PIX_W-1:0]  win_px;
  logic [CH_W-1:0]   win_ga;

  // highest priority wins; strict compare keeps the lower index on ties
  always_comb begin
    found  = 1'b0;
    best_i = '0;
    best_p = '0;
    for (int i = 0; i < NUM_LAYERS; i++) begin
      if (en[i] && cov[i] && (pipe_sel[i] == 1'(PIPE_ID)) &&
          (!found || (prio[i*PRIO_W +: PRIO_W] > best_p))) begin
        found  = 1'b1;
        best_p = prio[i*PRIO_W +: PRIO_W];
        best_i = IDX_W'(i);
      end
    end
  end

  assign win_px = pix[best_i*PIX_W +: PIX_W];
  assign win_ga = ga[best_i*CH_W +: CH_W];

  always_comb begin
    res.hit    = found;
    res.lowest = (best_p == '0);
    res.rgb    = win_px[RGB_W-1:0];
    if (ga_en[best_i])
      res.alpha = div255_round(16'(win_px[PIX_W-1:RGB_W]) * 16'(win_ga));
    else
      res.alpha = win_px[PIX_W-1:RGB_W];
  end

endmodule

// File: rtl/comp_alpha_blend.sv
module comp_alpha_blend
  import comp_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [CH_W-1:0]        alpha,
  input  logic [NUM_CH*CH_W-1:0] fg,
  input  logic [NUM_CH*CH_W-1:0] bg,
  output logic [NUM_CH*CH_W-1:0] mix
);

  logic [CH_W-1:0] inv_alpha;
  assign inv_alpha = 8'd255 - alpha;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [15:0] sum;
    assign sum = 16'(alpha) * 16'(fg[c*CH_W +: CH_W]) +
                 16'(inv_alpha) * 16'(bg[c*CH_W +: CH_W]);
    assign mix[c*CH_W +: CH_W] = div255_round(sum);
  end

endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int               NUM_LAYERS          = 4,
  parameter int               PRIO_W              = 2,
  parameter bit               LOWEST_ALPHA_DEFECT = 1'b0,
  parameter logic [RGB_W-1:0] BG_RESET            = 24'h000000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bg_wr,
  input  logic [RGB_W-1:0]             bg_data,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [NUM_LAYERS-1:0]        lay_en,
  input  logic [NUM_LAYERS-1:0]        lay_cov,
  input  logic [NUM_LAYERS-1:0]        lay_pipe,
  input  logic [NUM_LAYERS*PRIO_W-1:0] lay_prio,
  input  logic [NUM_LAYERS-1:0]        lay_ga_en,
  input  logic [NUM_LAYERS*CH_W-1:0]   lay_ga,
  input  logic [NUM_LAYERS*PIX_W-1:0]  lay_pix,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [RGB_W-1:0]             out_pixel
);

  localparam int NUM_PIPES = 2;
  localparam int NUM_CH    = RGB_W / CH_W;

  logic [RGB_W-1:0] bg_q;
  pipe_res_t        res [NUM_PIPES];
  logic [RGB_W-1:0] over_bg;
  logic [RGB_W-1:0] base0;
  logic             kill0;
  logic [RGB_W-1:0] base;
  logic [RGB_W-1:0] over_base;
  logic [RGB_W-1:0] mix;

  always_ff @(posedge clk) begin
    if (rst)        bg_q <= BG_RESET;
    else if (bg_wr) bg_q <= bg_data;
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    comp_pipe_arbiter #(
      .NUM_LAYERS (NUM_LAYERS),
      .PRIO_W     (PRIO_W),
      .PIPE_ID    (p)
    ) u_arb (
      .en       (lay_en),
      .cov      (lay_cov),
      .pipe_sel (lay_pipe),
      .prio     (lay_prio),
      .ga_en    (lay_ga_en),
      .ga       (lay_ga),
      .pix      (lay_pix),
      .res      (res[p])
    );
  end

  comp_alpha_blend #(.NUM_CH(NUM_CH)) u_blend_lo (
    .alpha (res[0].alpha),
    .fg    (res[0].rgb),
    .bg    (bg_q),
    .mix   (over_bg)
  );

  assign base0 = res[0].hit ? over_bg : bg_q;
  assign kill0 = LOWEST_ALPHA_DEFECT && res[0].hit && res[0].lowest &&
                 (res[0].alpha != 8'hFF);
  assign base  = kill0 ? bg_q : base0;

  comp_alpha_blend #(.NUM_CH(NUM_CH)) u_blend_hi (
    .alpha (res[1].alpha),
    .fg    (res[1].rgb),
    .bg    (base),
    .mix   (over_base)
  );

  assign mix = res[1].hit ? over_base : base;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pixel <= mix;
    end
  end

endmodule

// File: rtl/comp_checker.sv
module comp_checker #(
  parameter int NUM_LAYERS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [23:0]           out_pixel,
  input logic [NUM_LAYERS-1:0] lay_en,
  input logic [NUM_LAYERS-1:0] lay_cov,
  input logic [23:0]           bg_q
);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel));

  // R9
  accept_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready && !in_valid |=> !out_valid);

  // R7
  empty_gives_bg_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !(|(lay_en & lay_cov)) |=> out_pixel == $past(bg_q));

endmodule

bind layer_compositor comp_checker #(.NUM_LAYERS(NUM_LAYERS)) u_comp_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pixel (out_pixel),
  .lay_en    (lay_en),
  .lay_cov   (lay_cov),
  .bg_q      (bg_q)
);

// File: tb/layer_compositor_bench.sv
module layer_compositor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  typedef struct packed {
    logic [3:0]   en;
    logic [3:0]   cov;
    logic [3:0]   pipe;
    logic [3:0]   gaen;
    logic [7:0]   prio;
    logic [31:0]  ga;
    logic [127:0] pix;
    logic [23:0]  exp_n;
    logic [23:0]  exp_d;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2 R7: nothing enabled
    '{4'b0000, 4'b1111, 4'b0000, 4'b0000, 8'h00, 32'h0, {4{32'hFFFFFFFF}}, 24'h000000, 24'h000000},
    // R4: single opaque layer
    '{4'b0001, 4'b0001, 4'b0000, 4'b0000, 8'h00, 32'h0, {96'h0, 32'hFF112233}, 24'h112233, 24'h112233},
    // R3: higher priority wins in pipe 0
    '{4'b0011, 4'b0011, 4'b0000, 4'b0000, 8'h09, 32'h0, {64'h0, 32'hFF445566, 32'hFF112233}, 24'h445566, 24'h445566},
    // R2: uncovered layer ignored
    '{4'b0011, 4'b0001, 4'b0000, 4'b0000, 8'h09, 32'h0, {64'h0, 32'hFF445566, 32'hFF112233}, 24'h112233, 24'h112233},
    // R2: disabled layer ignored
    '{4'b0001, 4'b0011, 4'b0000, 4'b0000, 8'h09, 32'h0, {64'h0, 32'hFF445566, 32'hFF112233}, 24'h112233, 24'h112233},
    // R3: tie goes to lower index
    '{4'b0101, 4'b0101, 4'b0000, 4'b0000, 8'h22, 32'h0, {32'h0, 32'hFF00BB00, 32'h0, 32'hFFAA0000}, 24'hAA0000, 24'hAA0000},
    // R4: transparent pipe 1 over opaque pipe 0
    '{4'b0011, 4'b0011, 4'b0010, 4'b0000, 8'h00, 32'h0, {64'h0, 32'h00FFFFFF, 32'hFF102030}, 24'h102030, 24'h102030},
    // R4: half alpha on pipe 1 over empty pipe 0
    '{4'b0010, 4'b0010, 4'b0010, 4'b0000, 8'h00, 32'h0, {64'h0, 32'h80FFFFFF, 32'h0}, 24'h808080, 24'h808080},
    // R5: global alpha 0x80 on opaque pixel
    '{4'b0010, 4'b0010, 4'b0010, 4'b0010, 8'h00, 32'h00008000, {64'h0, 32'hFFFFFFFF, 32'h0}, 24'h808080, 24'h808080},
    // R6: global alpha ignored when enable clear
    '{4'b0010, 4'b0010, 4'b0010, 4'b0000, 8'h00, 32'h0, {64'h0, 32'hFFFFFFFF, 32'h0}, 24'hFFFFFF, 24'hFFFFFF},
    // R5: global alpha 0 hides the layer
    '{4'b0010, 4'b0010, 4'b0010, 4'b0010, 8'h00, 32'h0, {64'h0, 32'hFFFFFFFF, 32'h0}, 24'h000000, 24'h000000},
    // R4: red half over blue
    '{4'b1001, 4'b1001, 4'b1000, 4'b0000, 8'h00, 32'h0, {32'h80FF0000, 64'h0, 32'hFF0000FF}, 24'h80007F, 24'h80007F},
    // R3: priority in pipe 1
    '{4'b1101, 4'b1101, 4'b1100, 4'b0000, 8'hC0, 32'h0, {32'hFF00FF00, 32'hFFFF0000, 32'h0, 32'hFF0000FF}, 24'h00FF00, 24'h00FF00},
    // R8: priority-0 pixel alpha on pipe 0
    '{4'b0001, 4'b0001, 4'b0000, 4'b0000, 8'h00, 32'h0, {96'h0, 32'h80FFFFFF}, 24'h808080, 24'h000000},
    // R8: priority-0 global alpha on pipe 0
    '{4'b0001, 4'b0001, 4'b0000, 4'b0001, 8'h00, 32'h80, {96'h0, 32'hFFFFFFFF}, 24'h808080, 24'h000000},
    // R8: priority 1 not affected
    '{4'b0001, 4'b0001, 4'b0000, 4'b0000, 8'h01, 32'h0, {96'h0, 32'h80FFFFFF}, 24'h808080, 24'h808080}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bg_wr = 1'b0;
  logic [23:0] bg_data = '0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [NL-1:0] lay_en = '0, lay_cov = '0, lay_pipe = '0, lay_ga_en = '0;
  logic [NL*2-1:0] lay_prio = '0;
  logic [NL*8-1:0] lay_ga = '0;
  logic [NL*32-1:0] lay_pix = '0;
  logic in_ready_n, in_ready_d, out_valid_n, out_valid_d;
  logic [23:0] out_pixel_n, out_pixel_d;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_compositor u_layer_compositor (
    .clk, .rst, .bg_wr, .bg_data, .in_valid, .in_ready(in_ready_n),
    .lay_en, .lay_cov, .lay_pipe, .lay_prio, .lay_ga_en, .lay_ga, .lay_pix,
    .out_valid(out_valid_n), .out_ready, .out_pixel(out_pixel_n)
  );

  layer_compositor #(.LOWEST_ALPHA_DEFECT(1'b1)) u_layer_compositor_defect (
    .clk, .rst, .bg_wr, .bg_data, .in_valid, .in_ready(in_ready_d),
    .lay_en, .lay_cov, .lay_pipe, .lay_prio, .lay_ga_en, .lay_ga, .lay_pix,
    .out_valid(out_valid_d), .out_ready, .out_pixel(out_pixel_d)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    lay_en = v.en; lay_cov = v.cov; lay_pipe = v.pipe; lay_ga_en = v.gaen;
    lay_prio = v.prio; lay_ga = v.ga; lay_pix = v.pix;
  endtask

  task automatic run_one(input vec_t v, input string req);
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {23'h0, out_valid_n & out_valid_d}, 24'h1);
    check({req, " normal"}, out_pixel_n, v.exp_n);
    check({req, " defect"}, out_pixel_d, v.exp_d);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    vec_t t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {23'h0, out_valid_n}, 24'h0);
    check("R1 in_ready", {23'h0, in_ready_n}, 24'h1);
    t = VECS[0];
    run_one(t, "R1 black bg");

    for (int k = 0; k < NV; k++) run_one(VECS[k], $sformatf("vec%0d", k));

    // R7: background load
    @(negedge clk);
    bg_wr = 1'b1; bg_data = 24'h204060;
    @(negedge clk);
    bg_wr = 1'b0;
    t = VECS[0]; t.exp_n = 24'h204060; t.exp_d = 24'h204060;
    run_one(t, "R7 empty pipes show bg");
    t = VECS[7]; t.exp_n = 24'h90A0B0; t.exp_d = 24'h90A0B0;
    run_one(t, "R7 pipe1 over bg");
    // R8: defect replaces with the loaded background
    t = VECS[13]; t.exp_n = 24'h90A0B0; t.exp_d = 24'h204060;
    run_one(t, "R8 defect over bg");

    // R9: stall with new input waiting
    @(negedge clk);
    drive(VECS[1]); in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R9 first out", out_pixel_n, 24'h112233);
    check("R9 in_ready low when stalled", {23'h0, in_ready_n}, 24'h0);
    drive(VECS[2]);
    @(negedge clk);
    check("R9 held while stalled", out_pixel_n, 24'h112233);
    check("R9 still valid", {23'h0, out_valid_n}, 24'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second out after release", out_pixel_n, 24'h445566);
    @(negedge clk);
    check("R9 drained", {23'h0, out_valid_n}, 24'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule